// File: doc/BRIEF.md
# Lockable Watchdog Timer

A memory-mapped watchdog that counts down from a programmable reload value once per clock. Each time it reaches zero it raises a timeout flag and reloads. If the flag is still pending at the following zero and the reset function is enabled, the block raises a one-cycle system reset request. Software services the watchdog by clearing the flag through a write-to-clear register, or by rewriting the reload value. Writing the reload value also restarts the count.

The register bus is single-cycle. A write takes effect at the clock edge on which the select and write strobes are high. A read returns data combinationally in the same cycle. A lock register protects the control register against stray writes. A test register holds a stall bit: while that bit is set, the count freezes whenever a debugger halts the processor.

Word register map (word index on `bus_addr`):
- 0: reload value (read/write)
- 1: live count (read-only)
- 2: control. Bit 0 is the timer/interrupt enable. Bit 1 is the reset enable.
- 3: flag clear. Writing with bit 0 set clears the flag.
- 4: raw flag (bit 0)
- 5: masked flag (bit 0)
- 6: lock. A write of 32'h1ACC_E551 unlocks; any other value locks. A read returns 1 when locked.
- 7: test. Bit 0 is the stall enable.

Top module: `wdt_periph`

## Requirements
- R1: The reload register reads back exactly the value last written. After reset it holds the `RESET_LOAD` parameter.
- R2: The count register (word 1) returns the live count. A write to the reload register loads the counter with the new value at the same edge.
- R3: While control bit 0 is 0, the count holds. Once bit 0 is 1, the count decrements by one on every clock edge, starting from the edge after the control write.
- R4: On a clock edge where the running count is 0, the raw flag (word 4, bit 0) becomes 1 and the count reloads from the reload register.
- R5: The masked flag (word 5, bit 0) and the `irq` output equal the raw flag ANDed with control bit 0.
- R6: A flag-clear write (word 3) with bit 0 set clears the raw flag, the masked flag and `irq` at that edge. A flag-clear write with bit 0 clear has no effect.
- R7: With test bit 0 set, the count holds while `dbg_halt` is 1. It resumes decrementing once `dbg_halt` returns to 0.
- R8: With test bit 0 clear, `dbg_halt` has no effect on counting.
- R9: `rst_req` is high for exactly one cycle, in the cycle after a zero edge at which the raw flag was already 1 and control bit 1 was 1. It is never high when control bit 1 is 0.
- R10: The lock register reads 1 after any write other than 32'h1ACC_E551, and 0 after reset or after a write of that key. Control writes made while locked change nothing.
- R11: Once control bit 0 is set, only reset clears it. Control bit 1 follows each unlocked control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with select) |
| bus_addr | input | 3 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| dbg_halt | input | 1 | Processor halted by debugger |
| irq | output | 1 | Timeout interrupt (masked flag) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `CNT_W` = 16 and `RESET_LOAD` = 16'h0100. It then writes reload values of 3 to 6. With values that short, a full countdown, a second zero edge and the resulting reset pulse all fall within a few cycles, so they can be checked cycle by cycle. The narrower counter also exercises the zero-extension of the count and reload readback. The stall scenario freezes the counter while it is nonzero, which places the flag-clear writes where no timeout can coincide with them.

// File: rtl/wdt_pkg.sv
// Package: shared constants for the watchdog.
// Holds the word offsets of the register map and the unlock key.
// Assumes a 32-bit data bus and a 3-bit word index.
package wdt_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_RELOAD = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_COUNT  = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_LOCK   = 3'd6;
    localparam logic [ADDR_W-1:0] OFS_TEST   = 3'd7;

    localparam logic [BUS_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;
endpackage

// File: rtl/wdt_regs.sv
// Module: wdt_regs
// Decodes bus writes into the reload, control, lock and test registers.
// It also produces one-cycle strobes for reload and flag clear.
// Assumes CNT_W <= 32. Control writes are ignored while locked.
// The enable bit is sticky until reset.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  load_val,
    output logic              load_wr,
    output logic              clr_stb,
    output logic              irq_en,
    output logic              rst_en,
    output logic              locked,
    output logic              stall_en
);
    logic wr_any;
    logic ctrl_wr;

    // Qualified write strobes per register.
    always_comb begin
        wr_any  = bus_sel && bus_wr;
        load_wr = wr_any && (bus_addr == OFS_RELOAD);
        ctrl_wr = wr_any && (bus_addr == OFS_CTRL);
        clr_stb = wr_any && (bus_addr == OFS_CLEAR) && bus_wdata[0];
    end

    // Reload register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       load_val <= RESET_LOAD;
        else if (load_wr) load_val <= bus_wdata[CNT_W-1:0];
    end

    // Control bits, gated by the lock, with a sticky enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
            rst_en <= 1'b0;
        end else if (ctrl_wr && !locked) begin
            irq_en <= irq_en | bus_wdata[0];
            rst_en <= bus_wdata[1];
        end
    end

    // Lock state: the key unlocks, any other value locks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked <= 1'b0;
        else if (wr_any && (bus_addr == OFS_LOCK))
            locked <= (bus_wdata != UNLOCK_KEY);
    end

    // Debug-stall enable in the test register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stall_en <= 1'b0;
        else if (wr_any && (bus_addr == OFS_TEST))
            stall_en <= bus_wdata[0];
    end

    assert_lock_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && ctrl_wr) |=> ($stable(irq_en) && $stable(rst_en)));

    assert_sticky_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_en |=> irq_en);
endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Down-counter that runs while enabled.
// It freezes during a debug halt when stall is enabled and reloads at zero.
// A reload write takes priority and suppresses the zero event in that cycle.
module wdt_counter #(
    parameter int unsigned CNT_W = 32,
    parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             stall_en,
    input  logic             dbg_halt,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_wdata,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero_evt
);
    logic tick;

    // Decide whether this cycle advances the count, and detect expiry.
    always_comb begin
        tick     = run && !(stall_en && dbg_halt) && !load_wr;
        zero_evt = tick && (count == '0);
    end

    // Count register: reload write, expiry reload, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)        count <= RESET_LOAD;
        else if (load_wr)  count <= load_wdata;
        else if (zero_evt) count <= load_val;
        else if (tick)     count <= count - 1'b1;
    end

    assert_hold_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_wr) |=> $stable(count));

    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_en && dbg_halt && !load_wr) |=> $stable(count));

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> (count == $past(load_val)));
endmodule

// File: rtl/wdt_status.sv
// Module: wdt_status
// Keeps the raw timeout flag and generates the one-cycle reset request.
// The request fires when a zero event finds the flag still set with reset enabled.
// A set by a zero event wins over a clear in the same cycle.
module wdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_evt,
    input  logic clr_stb,
    input  logic rst_en,
    output logic raw_flag,
    output logic rst_req
);
    // Raw flag: set on expiry, cleared by the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        raw_flag <= 1'b0;
        else if (zero_evt) raw_flag <= 1'b1;
        else if (clr_stb)  raw_flag <= 1'b0;
    end

    // Reset request pulse on a second unserviced expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_req <= 1'b0;
        else        rst_req <= zero_evt && raw_flag && rst_en;
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && !zero_evt) |=> !raw_flag);

    assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> raw_flag);
endmodule

// File: rtl/wdt_periph.sv
// Module: wdt_periph
// Top level of the lockable watchdog.
// Joins the register decode, the counter and the status logic, and drives
// the combinational read mux. Assumes single-cycle bus accesses.
module wdt_periph
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32,
    parameter logic [CNT_W-1:0] RESET_LOAD = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              dbg_halt,
    output logic              irq,
    output logic              rst_req
);
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             load_wr, clr_stb, irq_en, rst_en, locked, stall_en;
    logic             zero_evt, raw_flag, masked_flag;

    wdt_regs #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .load_val(load_val),
        .load_wr(load_wr), .clr_stb(clr_stb), .irq_en(irq_en), .rst_en(rst_en),
        .locked(locked), .stall_en(stall_en)
    );

    wdt_counter #(.CNT_W(CNT_W), .RESET_LOAD(RESET_LOAD)) u_counter (
        .clk(clk), .rst_n(rst_n), .run(irq_en), .stall_en(stall_en),
        .dbg_halt(dbg_halt), .load_wr(load_wr),
        .load_wdata(bus_wdata[CNT_W-1:0]), .load_val(load_val),
        .count(count), .zero_evt(zero_evt)
    );

    wdt_status u_status (
        .clk(clk), .rst_n(rst_n), .zero_evt(zero_evt), .clr_stb(clr_stb),
        .rst_en(rst_en), .raw_flag(raw_flag), .rst_req(rst_req)
    );

    // Masked flag drives the interrupt line.
    always_comb begin
        masked_flag = raw_flag && irq_en;
        irq         = masked_flag;
    end

    // Combinational read mux over the register map.
    always_comb begin
        unique case (bus_addr)
            OFS_RELOAD: bus_rdata = BUS_W'(load_val);
            OFS_COUNT:  bus_rdata = BUS_W'(count);
            OFS_CTRL:   bus_rdata = BUS_W'({rst_en, irq_en});
            OFS_RAW:    bus_rdata = BUS_W'(raw_flag);
            OFS_MASKED: bus_rdata = BUS_W'(masked_flag);
            OFS_LOCK:   bus_rdata = BUS_W'(locked);
            OFS_TEST:   bus_rdata = BUS_W'(stall_en);
            default:    bus_rdata = '0;
        endcase
    end

    assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (raw_flag && irq_en));
endmodule

// File: tb/test_wdt_periph.sv
// Directed bench for wdt_periph: one task per scenario, each checking its own results.
module test_wdt_periph;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        irq;
    logic        rst_req;

    int checks = 0;
    int fails  = 0;

    localparam logic [31:0] KEY = 32'h1ACC_E551;

    wdt_periph #(.CNT_W(16), .RESET_LOAD(16'h0100)) i_wdt_periph (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt(dbg_halt), .irq(irq), .rst_req(rst_req)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; dbg_halt = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(3'd0, v); check("R1 reset reload", v, 32'h100);
        rd(3'd1, v); check("R2 reset count", v, 32'h100);
        rd(3'd2, v); check("R11 reset ctrl", v, 0);
        rd(3'd4, v); check("R4 reset raw", v, 0);
        rd(3'd6, v); check("R10 reset lock", v, 0);
        check("R9 reset rst_req", rst_req, 0);
        check("R5 reset irq", irq, 0);
    endtask

    task automatic t_run_and_expire();
        logic [31:0] v;
        logic seen;
        do_reset();
        wr(3'd0, 32'hABCD_0005);
        rd(3'd0, v); check("R1 reload readback", v, 32'h5);
        rd(3'd1, v); check("R2 count after reload write", v, 32'h5);
        repeat (3) @(negedge clk);
        rd(3'd1, v); check("R3 hold while disabled", v, 32'h5);
        wr(3'd2, 32'h1);
        rd(3'd1, v); check("R3 no tick at enable edge", v, 32'h5);
        @(negedge clk);
        rd(3'd1, v); check("R3 first decrement", v, 32'h4);
        repeat (4) @(negedge clk);
        rd(3'd1, v); check("R3 reached zero", v, 32'h0);
        rd(3'd4, v); check("R4 raw before expiry", v, 0);
        @(negedge clk);
        rd(3'd4, v); check("R4 raw after expiry", v, 1);
        rd(3'd1, v); check("R4 reload at expiry", v, 32'h5);
        rd(3'd5, v); check("R5 masked flag", v, 1);
        check("R5 irq line", irq, 1);
        seen = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1'b1;
        end
        check("R9 no request with reset disabled", seen, 0);
    endtask

    task automatic t_stall_and_clear();
        logic [31:0] v;
        do_reset();
        wr(3'd0, 32'h4);
        wr(3'd7, 32'h1);
        wr(3'd2, 32'h1);
        repeat (5) @(negedge clk);
        rd(3'd4, v); check("R4 raw set at first expiry", v, 1);
        rd(3'd1, v); check("R4 reloaded to 4", v, 32'h4);
        dbg_halt = 1'b1;
        repeat (3) @(negedge clk);
        rd(3'd1, v); check("R7 count frozen in halt", v, 32'h4);
        wr(3'd3, 32'h0);
        rd(3'd4, v); check("R6 clear with bit0=0 ignored", v, 1);
        wr(3'd3, 32'h1);
        rd(3'd4, v); check("R6 raw cleared", v, 0);
        rd(3'd5, v); check("R6 masked cleared", v, 0);
        check("R6 irq deasserted", irq, 0);
        dbg_halt = 1'b0;
        @(negedge clk);
        rd(3'd1, v); check("R7 resumes after halt", v, 32'h3);
    endtask

    task automatic t_no_stall();
        logic [31:0] v;
        do_reset();
        wr(3'd0, 32'h6);
        dbg_halt = 1'b1;
        wr(3'd2, 32'h1);
        repeat (3) @(negedge clk);
        rd(3'd1, v); check("R8 halt ignored without stall", v, 32'h3);
        dbg_halt = 1'b0;
    endtask

    task automatic t_reset_request();
        logic [31:0] bad;
        do_reset();
        wr(3'd0, 32'h3);
        wr(3'd2, 32'h3);
        bad = 0;
        for (int i = 1; i <= 11; i++) begin
            @(negedge clk);
            if (rst_req !== (i == 8)) bad = 32'(i);
        end
        check("R9 single pulse at second expiry (bad cycle index)", bad, 0);
    endtask

    task automatic t_lock();
        logic [31:0] v;
        do_reset();
        wr(3'd6, 32'h1234);
        rd(3'd6, v); check("R10 locked by other value", v, 1);
        wr(3'd2, 32'h3);
        rd(3'd2, v); check("R10 ctrl ignored while locked", v, 0);
        wr(3'd6, KEY);
        rd(3'd6, v); check("R10 unlocked by key", v, 0);
        wr(3'd2, 32'h1);
        rd(3'd2, v); check("R10 ctrl accepted when unlocked", v, 1);
        wr(3'd2, 32'h0);
        rd(3'd2, v); check("R11 enable sticky", v, 1);
        wr(3'd2, 32'h2);
        rd(3'd2, v); check("R11 reset enable follows write", v, 3);
        wr(3'd6, KEY ^ 32'h1);
        wr(3'd2, 32'h0);
        rd(3'd2, v); check("R10 relock blocks clear of bit1", v, 3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        t_reset_state();
        t_run_and_expire();
        t_stall_and_clear();
        t_no_stall();
        t_reset_request();
        t_lock();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule